// File: doc/BRIEF.md
# Bridge Read Prefetch Controller

This block sits on the slave side of a bus bridge. It takes each read that a processor-side master presents and decides how many bytes to ask for on the destination bus and where that request starts. The prefetch size comes from a 3-bit fetch code. Cache-line wrap reads always ask for one 32-byte line, starting at the beat the processor wants first. A read larger than the programmed size raises the request to the read's own size, because the processor side has no way to cut a transfer short.

In stream mode the block remembers the end of the fetched window and a running address. Later small reads at that running address are served from the window without a new request, and the running address steps forward by each read's size. When the window runs short, a follow-up request for the missing bytes starts where the window ends. The block also checks the configuration bits that allow 4-byte reads, and flags an 8-byte read on an image that is set up for 4-byte reads.

Top module: `rpf_ctrl`

## Requirements
- R1: On a read that misses the window, the request size is 8 << code for a fetch code of 0 to 4 (8, 16, 32, 64 or 128 bytes) whenever that is at least the read size, and `dq_wrap` is 0.
- R2: Fetch codes 5, 6 and 7 behave as code 0 (8 bytes). Any cycle after reset with such a code sets `cfg_err`, which then stays set until reset.
- R3: A read whose size (`pr_size` code n means 2^n bytes) exceeds the programmed amount requests the read size instead. A missing request starts at the read address aligned down to the request size. Read addresses are first aligned down to the read size.
- R4: A wrap read (`pr_wrap`=1) requests exactly 32 bytes at the address aligned down to 8 bytes, so it can start at any of the four beats of the line, with `dq_wrap`=1. It ignores the fetch code, stream mode and `pr_size`, and it empties the window.
- R5: In stream mode, a read at the running address that fits in the window pulses `pr_hit`, makes no request, and advances the running address by the read size.
- R6: In stream mode, a read at the running address that does not fit requests, at the window end, max(programmed amount, remainder rounded up to a power of two) bytes. The window is extended and the running address moves past the read.
- R7: A read at any other address, any write (`pr_write`=1), or any read with stream mode off, empties the window. The next read then misses.
- R8: A 4-byte read (size code 2) is allowed only when `cfg_memspace`=1, `cfg_narrow`=1 and `cfg_order` is not 2'b00. Otherwise it pulses `pr_err`, makes no request and leaves the window unchanged.
- R9: When the 4-byte conditions of R8 all hold, an 8-byte read (size code 3) pulses `pr_err` and makes no request. Without those conditions it is an ordinary read.
- R10: `dq_valid` with its address, size and wrap flag holds steady until `dq_ready`. `pr_ready` is low while a request is pending.
- R11: `pr_hit`, `pr_err` or `dq_valid` appears in the cycle after the read is accepted. Exactly one of them appears for every accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fetch_code | input | 3 | Prefetch amount code |
| cfg_stream | input | 1 | Stream mode: keep the window and step the running address |
| cfg_memspace | input | 1 | Image maps memory space (4-byte read qualifier) |
| cfg_narrow | input | 1 | Narrow read enable (4-byte read qualifier) |
| cfg_order | input | 2 | Byte order field; 2'b00 forbids 4-byte reads |
| pr_valid | input | 1 | Processor transaction present |
| pr_ready | output | 1 | Transaction accepted this cycle when high |
| pr_write | input | 1 | Transaction is a write |
| pr_wrap | input | 1 | Transaction is a cache-line wrap read |
| pr_size | input | 3 | Read size code, 2^n bytes |
| pr_addr | input | 32 | Transaction byte address |
| pr_hit | output | 1 | Read served from the window |
| pr_err | output | 1 | Read rejected by the 4/8-byte rules |
| dq_valid | output | 1 | Destination request pending |
| dq_ready | input | 1 | Destination side takes the request |
| dq_addr | output | 32 | Destination request start address |
| dq_bytes | output | 8 | Destination request byte count |
| dq_wrap | output | 1 | Request is a wrapping line fetch |
| cfg_err | output | 1 | Sticky reserved fetch code flag |

## Verification
The bench pushes the window to its edges. It drains the window to exactly zero bytes, which must produce a follow-up at the window end and not a hit or a realigned miss. It leaves 8 bytes for a 16-byte read, which must produce a remainder-sized request at the window end; a design that sized it from the whole read, or restarted at the read address, would fetch the wrong bytes. Wrap reads start at each of the four beats with stream mode and the largest fetch code set; a design that aligned them to the line or applied the code would return a wrong length or a wrong beat order. The bench toggles every qualifier bit for 4- and 8-byte reads, and stalls `dq_ready` for several cycles, which would expose a request whose fields change while it is pending.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WRITE,
    OP_REJECT,
    OP_HIT,
    OP_MISS,
    OP_FOLLOW,
    OP_WRAP
  } rpf_op_e;
endpackage

// File: rtl/rpf_amt_decode.sv
module rpf_amt_decode #(
  parameter int CW       = 8,
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 4,
  parameter int BASE_LOG = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CW-1:0]     amt_bytes_o,
  output logic              reserved_o
);
  logic [CODE_W-1:0] eff_code;

  always_comb begin
    reserved_o  = (int'(code_i) > MAX_CODE);
    eff_code    = reserved_o ? '0 : code_i;
    amt_bytes_o = CW'(1) << (BASE_LOG + int'(eff_code));
  end
endmodule

// File: rtl/rpf_qualify.sv
module rpf_qualify #(
  parameter int CW         = 8,
  parameter int SZW        = 3,
  parameter int NARROW_LOG = 2
) (
  input  logic [SZW-1:0] size_i,
  input  logic           memspace_i,
  input  logic           narrow_i,
  input  logic [1:0]     order_i,
  input  logic           is_write_i,
  input  logic           is_wrap_i,
  output logic [CW-1:0]  rd_bytes_o,
  output logic           reject_o
);
  logic narrow_ok;
  logic is_narrow;
  logic is_double;

  always_comb begin
    narrow_ok  = memspace_i && narrow_i && (order_i != 2'b00);
    is_narrow  = (int'(size_i) == NARROW_LOG);
    is_double  = (int'(size_i) == NARROW_LOG + 1);
    rd_bytes_o = CW'(1) << size_i;
    reject_o   = !is_write_i && !is_wrap_i &&
                 ((is_narrow && !narrow_ok) || (is_double && narrow_ok));
  end
endmodule

// File: rtl/rpf_plan.sv
module rpf_plan
  import rpf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CW       = 8,
  parameter int BEAT_LOG = 3,
  parameter int LINE_LOG = 5
) (
  input  logic          accept_i,
  input  logic          is_write_i,
  input  logic          is_wrap_i,
  input  logic          reject_i,
  input  logic          stream_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] rd_bytes_i,
  input  logic [CW-1:0] amt_bytes_i,
  input  logic          buf_valid_i,
  input  logic [AW-1:0] lat_addr_i,
  input  logic [AW-1:0] buf_end_i,
  output rpf_op_e       op_o,
  output logic [AW-1:0] req_addr_o,
  output logic [CW-1:0] req_bytes_o,
  output logic [AW-1:0] nxt_lat_o,
  output logic [AW-1:0] nxt_end_o
);
  localparam logic [AW-1:0] BEAT_MASK  = ~((AW'(1) << BEAT_LOG) - AW'(1));
  localparam logic [CW-1:0] LINE_BYTES = CW'(1) << LINE_LOG;

  logic [AW-1:0] rb_wide;
  logic [AW-1:0] eff_addr;
  logic [AW-1:0] gap;
  logic [CW-1:0] avail;
  logic [CW-1:0] remain;
  logic [CW-1:0] miss_sz;
  logic [CW-1:0] rem_p2;
  logic [CW-1:0] follow_sz;
  logic [AW-1:0] miss_wide;
  logic          in_window;
  logic          fits;

  function automatic logic [CW-1:0] ceil_pow2(input logic [CW-1:0] v);
    logic [CW-1:0] r;
    r = '0;
    for (int i = CW - 1; i >= 0; i--) begin
      if ((CW'(1) << i) >= v) r = CW'(1) << i;
    end
    return r;
  endfunction

  always_comb begin
    rb_wide   = AW'(rd_bytes_i);
    eff_addr  = addr_i & ~(rb_wide - AW'(1));
    in_window = stream_i && buf_valid_i && (eff_addr == lat_addr_i);
    gap       = buf_end_i - lat_addr_i;
    avail     = gap[CW-1:0];
    fits      = (rd_bytes_i <= avail);
    remain    = rd_bytes_i - avail;
    rem_p2    = ceil_pow2(remain);
    miss_sz   = (rd_bytes_i > amt_bytes_i) ? rd_bytes_i : amt_bytes_i;
    follow_sz = (rem_p2 > amt_bytes_i) ? rem_p2 : amt_bytes_i;
    miss_wide = AW'(miss_sz);

    op_o        = OP_IDLE;
    req_addr_o  = eff_addr & ~(miss_wide - AW'(1));
    req_bytes_o = miss_sz;
    if (accept_i) begin
      if (is_write_i) begin
        op_o = OP_WRITE;
      end else if (is_wrap_i) begin
        op_o        = OP_WRAP;
        req_addr_o  = addr_i & BEAT_MASK;
        req_bytes_o = LINE_BYTES;
      end else if (reject_i) begin
        op_o = OP_REJECT;
      end else if (in_window && fits) begin
        op_o = OP_HIT;
      end else if (in_window) begin
        op_o        = OP_FOLLOW;
        req_addr_o  = buf_end_i;
        req_bytes_o = follow_sz;
      end else begin
        op_o = OP_MISS;
      end
    end
    nxt_lat_o = eff_addr + rb_wide;
    nxt_end_o = req_addr_o + AW'(req_bytes_o);
  end
endmodule

// File: rtl/rpf_track.sv
module rpf_track
  import rpf_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MAX_LOG = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rpf_op_e       op_i,
  input  logic          stream_i,
  input  logic [AW-1:0] nxt_lat_i,
  input  logic [AW-1:0] nxt_end_i,
  output logic          buf_valid_o,
  output logic [AW-1:0] lat_addr_o,
  output logic [AW-1:0] buf_end_o
);
  localparam logic [AW-1:0] MAX_BYTES = AW'(1) << MAX_LOG;

  logic          valid_n;
  logic [AW-1:0] lat_n;
  logic [AW-1:0] end_n;
  logic          trk_en;

  always_comb begin
    trk_en  = (op_i != OP_IDLE);
    valid_n = buf_valid_o;
    lat_n   = lat_addr_o;
    end_n   = buf_end_o;
    case (op_i)
      OP_HIT: lat_n = nxt_lat_i;
      OP_MISS: begin
        valid_n = stream_i;
        lat_n   = nxt_lat_i;
        end_n   = nxt_end_i;
      end
      OP_FOLLOW: begin
        valid_n = 1'b1;
        lat_n   = nxt_lat_i;
        end_n   = nxt_end_i;
      end
      OP_WRAP, OP_WRITE: valid_n = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid_o <= 1'b0;
      lat_addr_o  <= '0;
      buf_end_o   <= '0;
    end else if (trk_en) begin
      buf_valid_o <= valid_n;
      lat_addr_o  <= lat_n;
      buf_end_o   <= end_n;
    end
  end

  // R5: the running address never leaves the fetched window
  p_window_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid_o |-> ((buf_end_o - lat_addr_o) <= MAX_BYTES));
endmodule

// File: rtl/rpf_ctrl.sv
module rpf_ctrl
  import rpf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int MAX_LOG  = 7,
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 4,
  parameter int BASE_LOG = 3,
  parameter int BEAT_LOG = 3,
  parameter int LINE_LOG = 5,
  localparam int CW      = MAX_LOG + 1,
  localparam int SZW     = $clog2(MAX_LOG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cfg_fetch_code,
  input  logic              cfg_stream,
  input  logic              cfg_memspace,
  input  logic              cfg_narrow,
  input  logic [1:0]        cfg_order,
  input  logic              pr_valid,
  output logic              pr_ready,
  input  logic              pr_write,
  input  logic              pr_wrap,
  input  logic [SZW-1:0]    pr_size,
  input  logic [AW-1:0]     pr_addr,
  output logic              pr_hit,
  output logic              pr_err,
  output logic              dq_valid,
  input  logic              dq_ready,
  output logic [AW-1:0]     dq_addr,
  output logic [CW-1:0]     dq_bytes,
  output logic              dq_wrap,
  output logic              cfg_err
);
  localparam logic [CW-1:0] LINE_BYTES = CW'(1) << LINE_LOG;
  localparam logic [CW-1:0] MIN_BYTES  = CW'(1) << BASE_LOG;

  logic [CW-1:0] amt_bytes;
  logic          code_reserved;
  logic [CW-1:0] rd_bytes;
  logic          reject;
  logic          accept;
  rpf_op_e       op;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_bytes;
  logic [AW-1:0] nxt_lat;
  logic [AW-1:0] nxt_end;
  logic          buf_valid;
  logic [AW-1:0] lat_addr;
  logic [AW-1:0] buf_end;

  logic          start_req;
  logic          dq_valid_n;
  logic          hit_n;
  logic          err_n;
  logic          cerr_n;

  assign pr_ready = !dq_valid;
  assign accept   = pr_valid && pr_ready;

  rpf_amt_decode #(
    .CW(CW), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .BASE_LOG(BASE_LOG)
  ) u_amt (
    .code_i      (cfg_fetch_code),
    .amt_bytes_o (amt_bytes),
    .reserved_o  (code_reserved)
  );

  rpf_qualify #(
    .CW(CW), .SZW(SZW), .NARROW_LOG(2)
  ) u_qual (
    .size_i     (pr_size),
    .memspace_i (cfg_memspace),
    .narrow_i   (cfg_narrow),
    .order_i    (cfg_order),
    .is_write_i (pr_write),
    .is_wrap_i  (pr_wrap),
    .rd_bytes_o (rd_bytes),
    .reject_o   (reject)
  );

  rpf_plan #(
    .AW(AW), .CW(CW), .BEAT_LOG(BEAT_LOG), .LINE_LOG(LINE_LOG)
  ) u_plan (
    .accept_i    (accept),
    .is_write_i  (pr_write),
    .is_wrap_i   (pr_wrap),
    .reject_i    (reject),
    .stream_i    (cfg_stream),
    .addr_i      (pr_addr),
    .rd_bytes_i  (rd_bytes),
    .amt_bytes_i (amt_bytes),
    .buf_valid_i (buf_valid),
    .lat_addr_i  (lat_addr),
    .buf_end_i   (buf_end),
    .op_o        (op),
    .req_addr_o  (req_addr),
    .req_bytes_o (req_bytes),
    .nxt_lat_o   (nxt_lat),
    .nxt_end_o   (nxt_end)
  );

  rpf_track #(
    .AW(AW), .MAX_LOG(MAX_LOG)
  ) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .stream_i    (cfg_stream),
    .nxt_lat_i   (nxt_lat),
    .nxt_end_i   (nxt_end),
    .buf_valid_o (buf_valid),
    .lat_addr_o  (lat_addr),
    .buf_end_o   (buf_end)
  );

  always_comb begin
    start_req  = (op == OP_MISS) || (op == OP_FOLLOW) || (op == OP_WRAP);
    dq_valid_n = dq_valid;
    if (dq_valid && dq_ready) dq_valid_n = 1'b0;
    if (start_req) dq_valid_n = 1'b1;
    hit_n  = (op == OP_HIT);
    err_n  = (op == OP_REJECT);
    cerr_n = cfg_err || code_reserved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_valid <= 1'b0;
      pr_hit   <= 1'b0;
      pr_err   <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      dq_valid <= dq_valid_n;
      pr_hit   <= hit_n;
      pr_err   <= err_n;
      cfg_err  <= cerr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_addr  <= '0;
      dq_bytes <= '0;
      dq_wrap  <= 1'b0;
    end else if (start_req) begin
      dq_addr  <= req_addr;
      dq_bytes <= req_bytes;
      dq_wrap  <= (op == OP_WRAP);
    end
  end

  // R10: a pending request is frozen until taken
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid && !dq_ready |=> dq_valid && $stable(dq_addr) && $stable(dq_bytes) && $stable(dq_wrap));

  // R4: wrap requests are one beat-aligned line
  p_wrap_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid && dq_wrap |-> (dq_bytes == LINE_BYTES) && (dq_addr[BEAT_LOG-1:0] == '0));

  // R3: every request is a power of two of at least the smallest fetch
  p_req_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> ($countones(dq_bytes) == 1) && (dq_bytes >= MIN_BYTES));

  // R2: configuration error flag is sticky
  p_cfg_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R11: each accepted read yields exactly one response next cycle
  p_one_response_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && pr_ready && !pr_write |=> $countones({pr_hit, pr_err, dq_valid}) == 1);
endmodule

// File: tb/sim_rpf_ctrl.sv
module sim_rpf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_fetch_code;
  logic        cfg_stream, cfg_memspace, cfg_narrow;
  logic [1:0]  cfg_order;
  logic        pr_valid, pr_ready, pr_write, pr_wrap;
  logic [2:0]  pr_size;
  logic [31:0] pr_addr;
  logic        pr_hit, pr_err;
  logic        dq_valid, dq_ready, dq_wrap;
  logic [31:0] dq_addr;
  logic [7:0]  dq_bytes;
  logic        cfg_err;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    stall  = 0;
  int    scnt   = 0;
  int    cycles = 0;
  string cur_tag = "R11";

  // reference model state
  bit      m_v = 0, m_w = 0, m_hit = 0, m_err = 0, m_cerr = 0, m_bv = 0;
  longint  m_a = 0, m_b = 0, m_lat = 0, m_end = 0;

  always #5 clk = ~clk;

  rpf_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fetch_code(cfg_fetch_code), .cfg_stream(cfg_stream),
    .cfg_memspace(cfg_memspace), .cfg_narrow(cfg_narrow), .cfg_order(cfg_order),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_write(pr_write), .pr_wrap(pr_wrap),
    .pr_size(pr_size), .pr_addr(pr_addr), .pr_hit(pr_hit), .pr_err(pr_err),
    .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_addr(dq_addr), .dq_bytes(dq_bytes),
    .dq_wrap(dq_wrap), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // model update on the edge, compare a little after it
  always @(posedge clk) begin
    if (rst_n) begin
      bit     old_v, q;
      longint rb, amt, ea, av, r, s;
      old_v = m_v;
      m_hit = 0;
      m_err = 0;
      if (cfg_fetch_code > 4) m_cerr = 1;
      if (old_v && dq_ready) m_v = 0;
      if (pr_valid && !old_v) begin
        rb  = longint'(1) << pr_size;
        amt = (cfg_fetch_code > 4) ? 8 : (longint'(8) << cfg_fetch_code);
        q   = cfg_memspace && cfg_narrow && (cfg_order != 2'b00);
        if (pr_write) m_bv = 0;
        else if (pr_wrap) begin
          m_v = 1; m_a = pr_addr & ~32'h7; m_b = 32; m_w = 1; m_bv = 0;
        end else if ((rb == 4 && !q) || (rb == 8 && q)) m_err = 1;
        else begin
          ea = pr_addr & ~(rb - 1);
          if (cfg_stream && m_bv && ea == m_lat) begin
            av = m_end - m_lat;
            if (rb <= av) begin
              m_hit = 1; m_lat = ea + rb;
            end else begin
              r = rb - av; s = 1;
              while (s < r) s = s * 2;
              if (s < amt) s = amt;
              m_v = 1; m_a = m_end; m_b = s; m_w = 0;
              m_lat = ea + rb; m_end = m_end + s;
            end
          end else begin
            s = (rb > amt) ? rb : amt;
            m_v = 1; m_a = ea & ~(s - 1); m_b = s; m_w = 0;
            m_bv = cfg_stream; m_lat = ea + rb; m_end = m_a + s;
          end
        end
        m_a   = m_a & 64'hFFFF_FFFF;
        m_lat = m_lat & 64'hFFFF_FFFF;
        m_end = m_end & 64'hFFFF_FFFF;
      end
    end
    #3;
    if (rst_n) begin
      chk(cur_tag, "dq_valid", dq_valid, m_v);
      if (m_v) begin
        chk(cur_tag, "dq_addr", dq_addr, m_a);
        chk(cur_tag, "dq_bytes", dq_bytes, m_b);
        chk(cur_tag, "dq_wrap", dq_wrap, m_w);
      end
      chk(cur_tag, "pr_hit", pr_hit, m_hit);
      chk(cur_tag, "pr_err", pr_err, m_err);
      chk("R2", "cfg_err", cfg_err, m_cerr);
      chk("R10", "pr_ready", pr_ready, !m_v);
    end
  end

  // destination side: accept after 'stall' cycles of valid
  always @(negedge clk) begin
    if (!rst_n) begin
      dq_ready <= 1'b0; scnt = 0;
    end else if (dq_valid) begin
      dq_ready <= (scnt >= stall);
      scnt = scnt + 1;
    end else begin
      dq_ready <= 1'b0; scnt = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  task automatic cfg(input [2:0] code, input bit strm, input bit mem, input bit nar, input [1:0] ord);
    cfg_fetch_code = code; cfg_stream = strm; cfg_memspace = mem; cfg_narrow = nar; cfg_order = ord;
  endtask

  task automatic xact(input [31:0] a, input [2:0] sz, input bit wr, input bit wp);
    while (!pr_ready) @(negedge clk);
    pr_valid = 1; pr_addr = a; pr_size = sz; pr_write = wr; pr_wrap = wp;
    @(negedge clk);
    pr_valid = 0; pr_write = 0; pr_wrap = 0;
  endtask

  task automatic rd(input [31:0] a, input [2:0] sz);
    xact(a, sz, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 0; pr_valid = 0; pr_write = 0; pr_wrap = 0; pr_size = 0; pr_addr = 0;
    cfg(3'd0, 1'b0, 1'b1, 1'b1, 2'b10);
    repeat (3) @(negedge clk);
    chk("R10", "reset pr_ready", pr_ready, 1);
    chk("R10", "reset dq_valid", dq_valid, 0);
    chk("R2", "reset cfg_err", cfg_err, 0);
    chk("R5", "reset pr_hit", pr_hit, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: each legal fetch code with a 4-byte read, no stream
    cur_tag = "R1";
    for (int c = 0; c <= 4; c++) begin
      cfg(3'(c), 1'b0, 1'b1, 1'b1, 2'b01);
      rd(32'h0000_1234 + 32'(c) * 32'h100, 3'd2);
    end
    // R3: reads larger than the programmed amount
    cur_tag = "R3";
    cfg(3'd0, 1'b0, 1'b1, 1'b1, 2'b10);
    rd(32'h1234_5664, 3'd5);
    rd(32'h0000_9F00, 3'd7);
    cfg(3'd1, 1'b0, 1'b0, 1'b0, 2'b00);
    rd(32'h0000_2038, 3'd6);
    rd(32'h0000_2039, 3'd0);
    // R10: stalled destination side
    cur_tag = "R10";
    stall = 3;
    rd(32'h0000_3040, 3'd4);
    wr_then();
    stall = 1;
    // R4: wrap reads at each beat, stream and large code set
    cur_tag = "R4";
    cfg(3'd4, 1'b1, 1'b1, 1'b1, 2'b10);
    for (int b = 0; b < 4; b++) xact(32'h0000_4000 + 32'(b) * 8 + 3, 3'd1, 1'b0, 1'b1);
    rd(32'h0000_4008, 3'd2);
    // R5: stream hits through a 64-byte window
    cur_tag = "R5";
    cfg(3'd3, 1'b1, 1'b1, 1'b1, 2'b10);
    rd(32'h0000_1000, 3'd2);
    for (int k = 1; k < 12; k++) rd(32'h0000_1000 + 32'(k) * 4, 3'd2);
    rd(32'h0000_1030, 3'd4);
    // R6: window drained to zero, then partial cover
    cur_tag = "R6";
    rd(32'h0000_1040, 3'd2);
    cfg(3'd0, 1'b1, 1'b1, 1'b1, 2'b10);
    rd(32'h0000_6000, 3'd2);
    rd(32'h0000_6004, 3'd2);
    cfg(3'd1, 1'b1, 1'b1, 1'b1, 2'b10);
    rd(32'h0000_6008, 3'd2);
    rd(32'h0000_600C, 3'd2);
    cfg(3'd0, 1'b1, 1'b1, 1'b1, 2'b10);
    rd(32'h0000_6010, 3'd4);
    rd(32'h0000_6020, 3'd2);
    // R7: mismatch, write and stream-off discards
    cur_tag = "R7";
    cfg(3'd3, 1'b1, 1'b1, 1'b1, 2'b10);
    rd(32'h0000_7000, 3'd2);
    rd(32'h0000_7004, 3'd2);
    rd(32'h0000_7020, 3'd2);
    xact(32'h0000_7024, 3'd2, 1'b1, 1'b0);
    rd(32'h0000_7024, 3'd2);
    cfg(3'd3, 1'b0, 1'b1, 1'b1, 2'b10);
    rd(32'h0000_7028, 3'd2);
    rd(32'h0000_702C, 3'd2);
    // R8: each missing qualifier rejects a 4-byte read
    cur_tag = "R8";
    cfg(3'd0, 1'b1, 1'b0, 1'b1, 2'b10); rd(32'h0000_8000, 3'd2);
    cfg(3'd0, 1'b1, 1'b1, 1'b0, 2'b10); rd(32'h0000_8000, 3'd2);
    cfg(3'd0, 1'b1, 1'b1, 1'b1, 2'b00); rd(32'h0000_8000, 3'd2);
    cfg(3'd0, 1'b1, 1'b1, 1'b1, 2'b01); rd(32'h0000_8000, 3'd2);
    rd(32'h0000_8004, 3'd2);
    // R9: 8-byte read misuse
    cur_tag = "R9";
    rd(32'h0000_9000, 3'd3);
    cfg(3'd0, 1'b1, 1'b1, 1'b1, 2'b00); rd(32'h0000_9000, 3'd3);
    // R2: reserved codes behave as 8 bytes and stick the flag
    cur_tag = "R2";
    for (int c = 5; c <= 7; c++) begin
      cfg(3'(c), 1'b0, 1'b1, 1'b1, 2'b10);
      rd(32'h0000_A004 + 32'(c) * 32'h40, 3'd2);
    end
    cfg(3'd2, 1'b0, 1'b1, 1'b1, 2'b10);
    rd(32'h0000_B000, 3'd2);
    cur_tag = "R11";
    repeat (10) @(negedge clk);
    summary();
  end

  task automatic wr_then();
    xact(32'h0000_3050, 3'd2, 1'b1, 1'b0);
    rd(32'h0000_3050, 3'd2);
  endtask
endmodule